// File: doc/BRIEF.md
# Multi-Mode Transmit Clock-Crossing FIFO

This block carries transmit words from a fabric-side write clock into a PCS-side read clock. Every entry holds a data word, a bit that marks the word as data or control, and a valid bit. A two-bit mode input picks one of four behaviours. Phase compensation moves one word on every clock between two clocks of equal frequency. Register mode skips the storage and gives a fixed one-cycle path. In framed elastic mode the user enables writes and a frame generator enables reads. Basic elastic mode has the same two enables, and the flags gate the reads.

The pointers cross between domains as Gray codes through two-stage synchronizers. Full and partial-full are computed in the write domain. Empty and partial-empty are computed in the read domain. Both partial thresholds are static inputs. A build-time option doubles the width of the write port so the write clock can run at half rate. Each wide entry is then read out as two narrow words, low half first. The mode may change only while both resets are held low.

Top module: `tx_mode_fifo`

## Requirements
- R1: While reset is held and after it is released with no traffic: empty is 1, full is 0, partial-empty is 1 (thresholds 3 and 12), partial-full is 0, overflow and underflow are 0, and the output word and valid are 0.
- R2: Mode 0 (phase compensation) stores the write word on every write-clock edge, whatever the write enable is, and stores a valid bit of 1 whatever the valid input is. It reads whenever the FIFO is not empty. Words come out in order, one per read clock, with valid high.
- R3: Mode 1 (register) presents the write-port data, the control bit of lane 0 and the valid bit of lane 0 at the outputs exactly one read-clock edge after they are captured. The storage stays empty.
- R4: Mode 2 (framed elastic) writes only on edges where the write enable is high, and reads only on edges where the read enable is high.
- R5: Mode 3 (basic elastic) reads only when the read enable is high and the FIFO is not empty. A read enable while the FIFO is empty has no effect and never sets underflow.
- R6: Words come out in write order, and each output control bit is the one written with its word.
- R7: Empty is 1 exactly when no entries are held. Full is 1 exactly when all 16 entries are held. Both are judged once the pointer synchronizers have settled.
- R8: Partial-empty is 1 when the occupancy is at or below its threshold. Partial-full is 1 when the occupancy is at or above its threshold. Occupancy counts write-side entries.
- R9: A write attempted while full is dropped, leaves the write pointer unchanged and sets a sticky overflow bit.
- R10: In mode 2, a read enable while empty leaves valid low, holds the last output word and sets a sticky underflow bit.
- R11: With the double-rate option, each wide entry is read out as two words: first bits [DATA_W-1:0] with control bit 0 and valid bit 0, then the upper half with control bit 1 and valid bit 1.
- R12: Reset clears the pointers, the flags and both sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous active-low reset |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous active-low reset |
| mode | input | 2 | 0 phase, 1 register, 2 framed elastic, 3 basic elastic |
| pfull_thr | input | log2(DEPTH)+1 | Partial-full occupancy threshold |
| pempty_thr | input | log2(DEPTH)+1 | Partial-empty occupancy threshold |
| wr_en | input | 1 | Write enable (modes 2 and 3) |
| wr_data | input | LANES*DATA_W | Write word, lane 0 in the low bits |
| wr_ctl | input | LANES | Data(0)/control(1) marker per lane |
| wr_valid | input | LANES | Valid bit per lane |
| wr_full | output | 1 | All entries held |
| wr_pfull | output | 1 | Occupancy at or above pfull_thr |
| wr_overflow | output | 1 | Sticky: a write was dropped |
| rd_en | input | 1 | Read enable (user in mode 3, frame generator in mode 2) |
| rd_data | output | DATA_W | Output word |
| rd_ctl | output | 1 | Output data/control marker |
| rd_valid | output | 1 | Output word valid |
| rd_empty | output | 1 | No entry held |
| rd_pempty | output | 1 | Occupancy at or below pempty_thr |
| rd_underflow | output | 1 | Sticky: a framed read found the FIFO empty |

## Verification
The bench sweeps every fill level from 0 to 16 in basic mode. At each level it checks the four flags against the occupancy, then drains and compares the stream. This separates off-by-one errors in the flags from errors in ordering and in the control bit. Writing 20 words without reads tests the drop and sticky logic. Framed traffic with enables held low shows the gating on both sides, and the read after the last word shows the underflow rule. A free-running count in phase mode with valid held low tests the forced valid and the gap-free flow. Register mode uses a changing pattern, which shows that the latency is one edge and not two. A second instance with a half-rate write clock checks the order in which lanes are split.

// File: rtl/tx_fifo_pkg.sv
// Package: types shared by the transmit clock-crossing FIFO.
// Assumes: the mode encoding is fixed and is decoded by the top and the checker.
package tx_fifo_pkg;

    typedef enum logic [1:0] {
        MODE_PHASE  = 2'd0,
        MODE_REG    = 2'd1,
        MODE_FRAMED = 2'd2,
        MODE_BASIC  = 2'd3
    } fifo_mode_e;

endpackage

// File: rtl/tx_fifo_sync.sv
// Module: two-stage synchronizer for a Gray-coded pointer. It also gives the
// binary value of the synchronized pointer.
// Assumes: the input changes by at most one bit per source clock (Gray code).
module tx_fifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_gray,
    output logic [W-1:0] q_gray,
    output logic [W-1:0] q_bin
);

    logic [W-1:0] meta_q;

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Two flops in the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_gray <= '0;
        end else begin
            meta_q <= d_gray;
            q_gray <= meta_q;
        end
    end

    // Binary form of the synchronized pointer, used for the occupancy.
    assign q_bin = gray_to_bin(q_gray);

endmodule

// File: rtl/tx_fifo_wr_ctrl.sv
// Module: write-side pointer, full and partial-full flags, and sticky overflow.
// Assumes: AW >= 2. The read pointer comes in already synchronized into wr_clk.
module tx_fifo_wr_ctrl #(
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          push_req,
    input  logic [AW:0]   rptr_gray_s,
    input  logic [AW:0]   rptr_bin_s,
    input  logic [AW:0]   pfull_thr,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wptr_gray,
    output logic          full,
    output logic          pfull,
    output logic          overflow
);

    logic [AW:0] wbin_q;
    logic [AW:0] wbin_nxt;
    logic [AW:0] used;

    // Full: the pointers differ only in the wrap bit, seen in Gray form.
    assign full     = (wptr_gray == {~rptr_gray_s[AW:AW-1], rptr_gray_s[AW-2:0]});
    assign push     = push_req && !full;
    assign wbin_nxt = wbin_q + {{AW{1'b0}}, push};
    assign waddr    = wbin_q[AW-1:0];

    // Occupancy as seen from the write side.
    assign used  = wbin_q - rptr_bin_s;
    assign pfull = (used >= pfull_thr);

    // Pointer register in binary and in Gray.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin_q    <= '0;
            wptr_gray <= '0;
        end else begin
            wbin_q    <= wbin_nxt;
            wptr_gray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Sticky overflow: a write was attempted while full.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            overflow <= 1'b0;
        end else if (push_req && full) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_fifo_rd_ctrl.sv
// Module: read-side pointer, empty and partial-empty flags, and sticky underflow.
// Assumes: last_lane is 1 on the read that completes an entry. The write
// pointer comes in already synchronized into rd_clk.
module tx_fifo_rd_ctrl #(
    parameter int AW = 4
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          pop_req,
    input  logic          uf_en,
    input  logic          last_lane,
    input  logic [AW:0]   wptr_gray_s,
    input  logic [AW:0]   wptr_bin_s,
    input  logic [AW:0]   pempty_thr,
    output logic          fire,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr_gray,
    output logic          empty,
    output logic          pempty,
    output logic          underflow
);

    logic [AW:0] rbin_q;
    logic [AW:0] rbin_nxt;
    logic [AW:0] used;
    logic        advance;

    assign empty    = (rptr_gray == wptr_gray_s);
    assign fire     = pop_req && !empty;
    assign advance  = fire && last_lane;
    assign rbin_nxt = rbin_q + {{AW{1'b0}}, advance};
    assign raddr    = rbin_q[AW-1:0];

    // Occupancy as seen from the read side.
    assign used   = wptr_bin_s - rbin_q;
    assign pempty = (used <= pempty_thr);

    // Pointer register in binary and in Gray.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin_q    <= '0;
            rptr_gray <= '0;
        end else begin
            rbin_q    <= rbin_nxt;
            rptr_gray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Sticky underflow: an enabled read found no entry.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            underflow <= 1'b0;
        end else if (pop_req && empty && uf_en) begin
            underflow <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_mode_fifo.sv
// Module: transmit FIFO crossing from the write clock to the read clock, with
// four run-time modes (phase, register, framed elastic, basic elastic) and a
// build-time double-width write port.
// Assumes: DEPTH is a power of two and at least 4. mode changes only while both
// resets are low. In register mode rd_clk is the same clock as wr_clk.
module tx_mode_fifo #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 16,
    parameter int DBL_RATE = 0
) (
    input  logic                                   wr_clk,
    input  logic                                   wr_rst_n,
    input  logic                                   rd_clk,
    input  logic                                   rd_rst_n,
    input  logic [1:0]                             mode,
    input  logic [$clog2(DEPTH):0]                 pfull_thr,
    input  logic [$clog2(DEPTH):0]                 pempty_thr,
    input  logic                                   wr_en,
    input  logic [(DBL_RATE != 0 ? 2 : 1)*DATA_W-1:0] wr_data,
    input  logic [(DBL_RATE != 0 ? 2 : 1)-1:0]     wr_ctl,
    input  logic [(DBL_RATE != 0 ? 2 : 1)-1:0]     wr_valid,
    output logic                                   wr_full,
    output logic                                   wr_pfull,
    output logic                                   wr_overflow,
    input  logic                                   rd_en,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   rd_ctl,
    output logic                                   rd_valid,
    output logic                                   rd_empty,
    output logic                                   rd_pempty,
    output logic                                   rd_underflow
);

    import tx_fifo_pkg::*;

    localparam int AW    = $clog2(DEPTH);
    localparam int LANES = (DBL_RATE != 0) ? 2 : 1;
    localparam int WR_W  = LANES * DATA_W;

    fifo_mode_e mode_e;
    logic       push_req;
    logic       push;
    logic       pop_req;
    logic       uf_en;
    logic       rd_fire;
    logic       last_lane;

    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wptr_gray;
    logic [AW:0]   rptr_gray;
    logic [AW:0]   wptr_gray_s;
    logic [AW:0]   wptr_bin_s;
    logic [AW:0]   rptr_gray_s;
    logic [AW:0]   rptr_bin_s;

    logic [WR_W-1:0]  mem_d [DEPTH];
    logic [LANES-1:0] mem_c [DEPTH];
    logic [LANES-1:0] mem_v [DEPTH];
    logic [LANES-1:0] wr_v_eff;

    logic [WR_W-1:0]   entry_d;
    logic [LANES-1:0]  entry_c;
    logic [LANES-1:0]  entry_v;
    logic [DATA_W-1:0] pick_d;
    logic              pick_c;
    logic              pick_v;

    assign mode_e = fifo_mode_e'(mode);

    // Write request per mode: phase always writes, register never uses storage.
    always_comb begin
        case (mode_e)
            MODE_PHASE: push_req = 1'b1;
            MODE_REG:   push_req = 1'b0;
            default:    push_req = wr_en;
        endcase
    end

    // Read request per mode: phase drains whenever there is data.
    always_comb begin
        case (mode_e)
            MODE_PHASE: pop_req = 1'b1;
            MODE_REG:   pop_req = 1'b0;
            default:    pop_req = rd_en;
        endcase
    end

    assign uf_en    = (mode_e == MODE_FRAMED);
    assign wr_v_eff = (mode_e == MODE_PHASE) ? {LANES{1'b1}} : wr_valid;

    // Storage write port in the write domain.
    always_ff @(posedge wr_clk) begin
        if (push) begin
            mem_d[waddr] <= wr_data;
            mem_c[waddr] <= wr_ctl;
            mem_v[waddr] <= wr_v_eff;
        end
    end

    tx_fifo_wr_ctrl #(.AW(AW)) u_wr_ctrl (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .push_req    (push_req),
        .rptr_gray_s (rptr_gray_s),
        .rptr_bin_s  (rptr_bin_s),
        .pfull_thr   (pfull_thr),
        .push        (push),
        .waddr       (waddr),
        .wptr_gray   (wptr_gray),
        .full        (wr_full),
        .pfull       (wr_pfull),
        .overflow    (wr_overflow)
    );

    tx_fifo_sync #(.W(AW + 1)) u_rptr_sync (
        .clk    (wr_clk),
        .rst_n  (wr_rst_n),
        .d_gray (rptr_gray),
        .q_gray (rptr_gray_s),
        .q_bin  (rptr_bin_s)
    );

    tx_fifo_sync #(.W(AW + 1)) u_wptr_sync (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .d_gray (wptr_gray),
        .q_gray (wptr_gray_s),
        .q_bin  (wptr_bin_s)
    );

    tx_fifo_rd_ctrl #(.AW(AW)) u_rd_ctrl (
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .pop_req     (pop_req),
        .uf_en       (uf_en),
        .last_lane   (last_lane),
        .wptr_gray_s (wptr_gray_s),
        .wptr_bin_s  (wptr_bin_s),
        .pempty_thr  (pempty_thr),
        .fire        (rd_fire),
        .raddr       (raddr),
        .rptr_gray   (rptr_gray),
        .empty       (rd_empty),
        .pempty      (rd_pempty),
        .underflow   (rd_underflow)
    );

    assign entry_d = mem_d[raddr];
    assign entry_c = mem_c[raddr];
    assign entry_v = mem_v[raddr];

    generate
        if (LANES == 2) begin : g_dbl
            logic lane_q;

            // Lane toggle: low half first, then high half of each entry.
            always_ff @(posedge rd_clk) begin
                if (!rd_rst_n) begin
                    lane_q <= 1'b0;
                end else if (rd_fire) begin
                    lane_q <= ~lane_q;
                end
            end

            assign last_lane = lane_q;
            assign pick_d    = lane_q ? entry_d[WR_W-1:DATA_W] : entry_d[DATA_W-1:0];
            assign pick_c    = entry_c[lane_q];
            assign pick_v    = entry_v[lane_q];
        end else begin : g_sgl
            assign last_lane = 1'b1;
            assign pick_d    = entry_d;
            assign pick_c    = entry_c[0];
            assign pick_v    = entry_v[0];
        end
    endgenerate

    // Output register: bypass in register mode, FIFO word otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_data  <= '0;
            rd_ctl   <= 1'b0;
            rd_valid <= 1'b0;
        end else if (mode_e == MODE_REG) begin
            rd_data  <= wr_data[DATA_W-1:0];
            rd_ctl   <= wr_ctl[0];
            rd_valid <= wr_valid[0];
        end else if (rd_fire) begin
            rd_data  <= pick_d;
            rd_ctl   <= pick_c;
            rd_valid <= pick_v;
        end else begin
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_fifo_chk.sv
// Module: protocol checker for tx_mode_fifo, attached with bind.
// Assumes: in register mode rd_clk is the same clock as wr_clk.
module tx_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic [1:0]        mode,
    input logic              push_req,
    input logic              wr_full,
    input logic [AW:0]       wptr_gray,
    input logic              wr_overflow,
    input logic              pop_req,
    input logic              rd_empty,
    input logic              rd_underflow,
    input logic [DATA_W-1:0] wr_lo,
    input logic              wr_c0,
    input logic              wr_v0,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ctl,
    input logic              rd_valid
);

    import tx_fifo_pkg::*;

    // R9: a write while full leaves the pointer unchanged.
    p_drop_when_full_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && push_req) |=> $stable(wptr_gray));

    // R9: a write while full sets overflow.
    p_overflow_set_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && push_req) |=> wr_overflow);

    // R9: overflow stays set until reset.
    p_overflow_sticky_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |=> wr_overflow);

    // R10: underflow stays set until reset.
    p_underflow_sticky_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_underflow |=> rd_underflow);

    // R10: a read request on an empty FIFO gives no valid and holds the word.
    p_empty_read_novalid_r10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (pop_req && rd_empty) |=> (!rd_valid && $stable(rd_data)));

    // R3: register mode has one edge of latency on data, control and valid.
    p_reg_latency_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ($past(rd_rst_n) && mode == MODE_REG && $past(mode) == MODE_REG) |->
        (rd_data == $past(wr_lo) && rd_ctl == $past(wr_c0) && rd_valid == $past(wr_v0)));

    // R5: basic mode never reports underflow.
    p_basic_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (mode == MODE_BASIC) |-> !rd_underflow);

endmodule

bind tx_mode_fifo tx_fifo_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .mode         (mode),
    .push_req     (push_req),
    .wr_full      (wr_full),
    .wptr_gray    (wptr_gray),
    .wr_overflow  (wr_overflow),
    .pop_req      (pop_req),
    .rd_empty     (rd_empty),
    .rd_underflow (rd_underflow),
    .wr_lo        (wr_data[DATA_W-1:0]),
    .wr_c0        (wr_ctl[0]),
    .wr_v0        (wr_valid[0]),
    .rd_data      (rd_data),
    .rd_ctl       (rd_ctl),
    .rd_valid     (rd_valid)
);

// File: tb/tx_mode_fifo_tb_top.sv
module tx_mode_fifo_tb_top;

    localparam int DW = 8;
    localparam int DEP = 16;
    localparam int AW = 4;

    logic clk  = 1'b0;
    logic clk2 = 1'b0;
    always #2 clk  = ~clk;
    always #4 clk2 = ~clk2;

    int n_vec = 0;
    int n_err = 0;

    logic [AW:0] pf_thr = 5'd12;
    logic [AW:0] pe_thr = 5'd3;

    // Single-rate instance signals.
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd3;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [0:0]    wr_ctl = '0;
    logic [0:0]    wr_valid = '0;
    logic          rd_en = 1'b0;
    logic          wr_full, wr_pfull, wr_overflow;
    logic [DW-1:0] rd_data;
    logic          rd_ctl, rd_valid, rd_empty, rd_pempty, rd_underflow;

    // Double-rate instance signals.
    logic            rst2_n = 1'b0;
    logic            wr_en2 = 1'b0;
    logic [2*DW-1:0] wr_data2 = '0;
    logic [1:0]      wr_ctl2 = '0;
    logic [1:0]      wr_valid2 = '0;
    logic            rd_en2 = 1'b0;
    logic            wr_full2, wr_pfull2, wr_overflow2;
    logic [DW-1:0]   rd_data2;
    logic            rd_ctl2, rd_valid2, rd_empty2, rd_pempty2, rd_underflow2;

    logic [8:0] got [64];
    int         got_n;

    tx_mode_fifo #(.DATA_W(DW), .DEPTH(DEP), .DBL_RATE(0)) dut_i (
        .wr_clk(clk), .wr_rst_n(rst_n), .rd_clk(clk), .rd_rst_n(rst_n),
        .mode(mode), .pfull_thr(pf_thr), .pempty_thr(pe_thr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ctl(wr_ctl), .wr_valid(wr_valid),
        .wr_full(wr_full), .wr_pfull(wr_pfull), .wr_overflow(wr_overflow),
        .rd_en(rd_en), .rd_data(rd_data), .rd_ctl(rd_ctl), .rd_valid(rd_valid),
        .rd_empty(rd_empty), .rd_pempty(rd_pempty), .rd_underflow(rd_underflow)
    );

    tx_mode_fifo #(.DATA_W(DW), .DEPTH(DEP), .DBL_RATE(1)) dut_dbl_i (
        .wr_clk(clk2), .wr_rst_n(rst2_n), .rd_clk(clk), .rd_rst_n(rst2_n),
        .mode(2'd3), .pfull_thr(pf_thr), .pempty_thr(pe_thr),
        .wr_en(wr_en2), .wr_data(wr_data2), .wr_ctl(wr_ctl2), .wr_valid(wr_valid2),
        .wr_full(wr_full2), .wr_pfull(wr_pfull2), .wr_overflow(wr_overflow2),
        .rd_en(rd_en2), .rd_data(rd_data2), .rd_ctl(rd_ctl2), .rd_valid(rd_valid2),
        .rd_empty(rd_empty2), .rd_pempty(rd_pempty2), .rd_underflow(rd_underflow2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_word(input int base, input int i);
        logic [7:0] d;
        d = 8'(base + i * 3);
        return {i[0], d};
    endfunction

    task automatic do_reset(input logic [1:0] m);
        @(posedge clk); #1;
        rst_n = 1'b0; mode = m; wr_en = 1'b0; rd_en = 1'b0;
        wr_data = '0; wr_ctl = '0; wr_valid = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic push_words(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1;
            wr_data = exp_word(base, i) & 9'h0FF;
            wr_ctl = i[0];
        end
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic drain(input int cycles);
        got_n = 0;
        @(posedge clk); #1 rd_en = 1'b1;
        repeat (cycles) begin
            @(negedge clk);
            if (rd_valid && got_n < 64) begin
                got[got_n] = {rd_ctl, rd_data};
                got_n++;
            end
        end
        rd_en = 1'b0;
    endtask

    task automatic pulse_rd();
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state.
        do_reset(2'd3);
        @(negedge clk);
        chk("R1 empty", rd_empty, 1);
        chk("R1 full", wr_full, 0);
        chk("R1 pempty", rd_pempty, 1);
        chk("R1 pfull", wr_pfull, 0);
        chk("R1 overflow", wr_overflow, 0);
        chk("R1 underflow", rd_underflow, 0);
        chk("R1 valid", rd_valid, 0);
        chk("R1 data", rd_data, 0);

        // R7 R8 R6 R5: sweep of fill levels in basic mode.
        for (int n = 0; n <= DEP; n++) begin
            do_reset(2'd3);
            push_words(n, n * 5);
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk("R7 empty", rd_empty, (n == 0));
            chk("R7 full", wr_full, (n == DEP));
            chk("R8 pempty", rd_pempty, (n <= 3));
            chk("R8 pfull", wr_pfull, (n >= 12));
            drain(n + 10);
            chk("R6 count", got_n, n);
            for (int k = 0; k < n && k < got_n; k++) begin
                chk("R6 word", got[k], exp_word(n * 5, k));
            end
            chk("R5 no underflow", rd_underflow, 0);
            chk("R7 empty after drain", rd_empty, 1);
        end

        // R9: overflow drops the extra words.
        do_reset(2'd3);
        push_words(20, 8'h40);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R9 full", wr_full, 1);
        chk("R9 overflow", wr_overflow, 1);
        drain(30);
        chk("R9 count", got_n, DEP);
        for (int k = 0; k < DEP && k < got_n; k++) begin
            chk("R9 word", got[k], exp_word(8'h40, k));
        end
        chk("R9 overflow held", wr_overflow, 1);

        // R12: reset clears the sticky bits and the flags.
        do_reset(2'd3);
        @(negedge clk);
        chk("R12 overflow", wr_overflow, 0);
        chk("R12 empty", rd_empty, 1);
        chk("R12 full", wr_full, 0);

        // R4 R10: framed mode.
        do_reset(2'd2);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1 wr_data = 8'(i + 1);
        end
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R4 no write without enable", rd_empty, 1);
        push_words(2, 8'h10);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R4 no read without enable", rd_empty, 0);
        chk("R4 no valid without enable", rd_valid, 0);
        pulse_rd();
        chk("R4 first valid", rd_valid, 1);
        chk("R4 first word", {rd_ctl, rd_data}, exp_word(8'h10, 0));
        pulse_rd();
        chk("R4 second word", {rd_ctl, rd_data}, exp_word(8'h10, 1));
        pulse_rd();
        chk("R10 valid low", rd_valid, 0);
        chk("R10 word held", {rd_ctl, rd_data}, exp_word(8'h10, 1));
        chk("R10 underflow", rd_underflow, 1);
        do_reset(2'd3);
        @(negedge clk);
        chk("R12 underflow", rd_underflow, 0);

        // R2: phase mode, write enable and valid held low.
        do_reset(2'd0);
        wr_valid = 1'b0;
        got_n = 0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            wr_data = 8'(i + 1);
            wr_ctl = 1'(i + 1);
            @(negedge clk);
            if (rd_valid && got_n < 64) begin
                got[got_n] = {rd_ctl, rd_data};
                got_n++;
            end
        end
        chk("R2 flow count", (got_n >= 50), 1);
        for (int k = 0; k < 40 && k < got_n; k++) begin
            chk("R2 stream", got[k], {k[0], 8'(k)});
        end
        chk("R2 no overflow", wr_overflow, 0);

        // R3: register mode, one-edge latency.
        do_reset(2'd1);
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk); #1;
            wr_data = 8'(i * 7);
            wr_ctl = i[0];
            wr_valid = i[1];
            @(posedge clk);
            @(negedge clk);
            chk("R3 output", {rd_valid, rd_ctl, rd_data}, {i[1], i[0], 8'(i * 7)});
        end
        chk("R3 storage empty", rd_empty, 1);

        // R11: double-rate lane order.
        @(posedge clk2); #1 rst2_n = 1'b0;
        repeat (6) @(posedge clk2);
        #1 rst2_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk2); #1;
            wr_en2 = 1'b1;
            wr_data2 = {8'(8'hA0 + k), 8'(8'h50 + k)};
            wr_ctl2 = {k[0], ~k[0]};
            wr_valid2 = 2'b11;
        end
        @(posedge clk2); #1 wr_en2 = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R11 not empty", rd_empty2, 0);
        got_n = 0;
        @(posedge clk); #1 rd_en2 = 1'b1;
        repeat (14) begin
            @(negedge clk);
            if (rd_valid2 && got_n < 64) begin
                got[got_n] = {rd_ctl2, rd_data2};
                got_n++;
            end
        end
        rd_en2 = 1'b0;
        chk("R11 count", got_n, 8);
        for (int k = 0; k < 4; k++) begin
            chk("R11 low lane", got[2*k], {~k[0], 8'(8'h50 + k)});
            chk("R11 high lane", got[2*k+1], {k[0], 8'(8'hA0 + k)});
        end
        @(negedge clk);
        chk("R11 empty after", rd_empty2, 1);

        finish_run();
    end

endmodule